// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block runs Clause 22 management frames on a two-wire MDIO bus. A host programs it through six 32-bit words: a configuration word (clock divider and soft reset), a command word, a target word (PHY and register number), a write-data word, a read-data word and a flags word. Loading the write-data word launches a write frame. A 0-to-1 change of the read bit in the command word launches a read frame. The host then polls the flags word until the frame has finished.

MDC is derived from the system clock through a power-of-two divider. MDIO uses three signals: an output value, an output enable, and an input that the PHY drives during the turnaround and data phase of a read. A frame is sent MSB first. It consists of 32 preamble ones, the start pair 01, the opcode (10 read, 01 write), 5 PHY-address bits, 5 register bits, a turnaround pair and 16 data bits. The master changes MDIO after the falling edge of MDC and samples it on the rising edge.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the configuration word reads 0x00000007, and the command, target, read-data and flags words read 0. MDC is low and the MDIO output enable is low.
- R2: Word index 2 (target) keeps the PHY address in bits [12:8] and the register number in bits [4:0]. All other bits of this word read 0.
- R3: Writing word index 3 (write data) while idle sends this 64-bit frame: 32 ones, 01, 01, PHY, register, 10, then data[15:0] MSB first. The output enable is high for all 64 bits.
- R4: A divider field value n in configuration bits [2:0] gives an MDC high phase of 2^(n+1) system clocks. MDC is low whenever no frame is in progress.
- R5: A read frame starts only when a write to word index 1 (command) changes bit 0 from 0 to 1. Writing 1 while the bit is already 1 starts nothing.
- R6: A read frame drives 32 ones, 01, 10, PHY and register with the output enable high. From the turnaround to the end of the frame the enable is low. The 16 bits sampled on the rising MDC edges of the data phase appear in bits [15:0] of word index 4 (read data).
- R7: Bit 0 of word index 5 (flags) is BUSY. It is 1 while a frame is in progress and 0 once the frame is over.
- R8: Bit 2 of the flags word is NOTVALID. It is set when a read starts and clears when the read data is valid in the read-data word.
- R9: While configuration bit 31 (soft reset) is 1, any frame in progress is aborted within two cycles. BUSY and NOTVALID read 0, MDIO is released, MDC is low, and no new frame can start.
- R10: Write-data and read-command writes that arrive while a frame is in progress neither change that frame nor start another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host word index (0..5) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read-back of the addressed word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
The hardest cases to reach from the ports are host writes that land in the middle of a running frame. These are an extra write-data store and a fresh 0-to-1 read command arriving while BUSY is high, and a soft reset arriving during a read. The bench runs the frame capture and the interfering host writes in parallel branches, so the second writes land a dozen clocks into a frame. It then compares the whole captured serial stream with the first frame. For the soft-reset case it aborts a read and checks that both flag bits, MDC and the output enable have dropped. It then tries to launch a frame while the reset bit is still held, and finally runs a clean frame after the reset bit is released.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
   typedef enum logic [2:0] {
      RG_CFG   = 3'd0,
      RG_CMD   = 3'd1,
      RG_ADDR  = 3'd2,
      RG_WDATA = 3'd3,
      RG_RDATA = 3'd4,
      RG_IND   = 3'd5
   } mgmt_reg_e;

   localparam logic [1:0] OP_READ   = 2'b10;
   localparam logic [1:0] OP_WRITE  = 2'b01;
   localparam logic [1:0] SOF_BITS  = 2'b01;
   localparam logic [1:0] TA_WRITE  = 2'b10;
   localparam logic [1:0] TA_RELEASE = 2'b11;

   localparam int FLAG_BUSY  = 0;
   localparam int FLAG_NVAL  = 2;
   localparam int CFG_SRST   = 31;
   localparam int PHY_LSB    = 8;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise,
   output logic             fall
);
   localparam int CNT_W = (1 << DIV_W) + 1;
   localparam int SH_W  = DIV_W + 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] half_m1;
   logic [SH_W-1:0]  shamt;
   logic             wrap;

   assign shamt   = {1'b0, div} + SH_W'(1);
   assign half_m1 = (CNT_W'(1) << shamt) - CNT_W'(1);
   assign wrap    = run && (cnt == half_m1);
   assign rise    = wrap && !mdc;
   assign fall    = wrap && mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_mgmt_pkg::*;
#(
   parameter int PHY_W   = 5,
   parameter int REG_W   = 5,
   parameter int DATA_W  = 16,
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              start,
   input  logic              start_rd,
   input  logic [PHY_W-1:0]  phy,
   input  logic [REG_W-1:0]  regn,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rise,
   input  logic              fall,
   input  logic              mdio_i,
   output logic              busy,
   output logic              is_rd,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              done,
   output logic [DATA_W-1:0] rdata
);
   localparam int FRAME_LEN = PRE_LEN + 6 + PHY_W + REG_W + DATA_W;
   localparam int IDX_W     = $clog2(FRAME_LEN);
   localparam int TA_POS    = PRE_LEN + 4 + PHY_W + REG_W;
   localparam int DATA_POS  = TA_POS + 2;

   logic [FRAME_LEN-1:0] shreg;
   logic [IDX_W-1:0]     idx;
   logic                 last_bit;

   assign last_bit = (idx == IDX_W'(FRAME_LEN - 1));
   assign done     = busy && fall && last_bit && !abort;
   assign mdio_o   = busy ? shreg[FRAME_LEN-1] : 1'b1;
   assign mdio_oe  = busy && (!is_rd || (idx < IDX_W'(TA_POS)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         is_rd <= 1'b0;
         idx   <= '0;
         shreg <= '1;
         rdata <= '0;
      end else if (abort) begin
         busy  <= 1'b0;
         is_rd <= 1'b0;
         idx   <= '0;
      end else if (!busy) begin
         if (start) begin
            busy  <= 1'b1;
            is_rd <= start_rd;
            idx   <= '0;
            shreg <= {{PRE_LEN{1'b1}}, SOF_BITS,
                      (start_rd ? OP_READ : OP_WRITE), phy, regn,
                      (start_rd ? TA_RELEASE : TA_WRITE),
                      (start_rd ? {DATA_W{1'b1}} : wdata)};
         end
      end else begin
         if (rise && is_rd && (idx >= IDX_W'(DATA_POS)))
            rdata <= {rdata[DATA_W-2:0], mdio_i};
         if (fall) begin
            if (last_bit) begin
               busy  <= 1'b0;
               is_rd <= 1'b0;
               idx   <= '0;
            end else begin
               idx   <= idx + IDX_W'(1);
               shreg <= {shreg[FRAME_LEN-2:0], 1'b1};
            end
         end
      end
   end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
   import mdio_mgmt_pkg::*;
#(
   parameter int DIV_W   = 3,
   parameter int PHY_W   = 5,
   parameter int REG_W   = 5,
   parameter int DATA_W  = 16,
   parameter int PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_we,
   input  logic [2:0]  host_addr,
   input  logic [31:0] host_wdata,
   output logic [31:0] host_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   initial begin
      assert (DIV_W >= 1 && DIV_W <= 4) else $error("DIV_W out of range");
      assert (PHY_W >= 1 && PHY_W <= 8) else $error("PHY_W out of range");
      assert (REG_W >= 1 && REG_W <= 8) else $error("REG_W out of range");
      assert (DATA_W >= 2 && DATA_W <= 32) else $error("DATA_W out of range");
      assert (PRE_LEN >= 1) else $error("PRE_LEN must be positive");
   end

   logic              srst_q;
   logic [DIV_W-1:0]  div_q;
   logic              cmd_q;
   logic [PHY_W-1:0]  phy_q;
   logic [REG_W-1:0]  reg_q;
   logic [DATA_W-1:0] wdat_q;
   logic [DATA_W-1:0] stat_q;
   logic              nv_q;

   logic              eng_busy, eng_rd, eng_done;
   logic [DATA_W-1:0] eng_rdata;
   logic              mdc_rise, mdc_fall;
   logic              launch_ok, start_wr, start_rd;
   logic              unused_wbits;

   assign unused_wbits = ^host_wdata;
   assign launch_ok    = !eng_busy && !srst_q;
   assign start_wr     = host_we && (host_addr == RG_WDATA) && launch_ok;
   assign start_rd     = host_we && (host_addr == RG_CMD) && host_wdata[0]
                         && !cmd_q && launch_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srst_q <= 1'b0;
         div_q  <= '1;
         cmd_q  <= 1'b0;
         phy_q  <= '0;
         reg_q  <= '0;
         wdat_q <= '0;
      end else if (host_we) begin
         unique case (host_addr)
            RG_CFG: begin
               srst_q <= host_wdata[CFG_SRST];
               div_q  <= host_wdata[DIV_W-1:0];
            end
            RG_CMD:   cmd_q  <= host_wdata[0];
            RG_ADDR: begin
               phy_q <= host_wdata[PHY_LSB +: PHY_W];
               reg_q <= host_wdata[0 +: REG_W];
            end
            RG_WDATA: wdat_q <= host_wdata[DATA_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nv_q   <= 1'b0;
         stat_q <= '0;
      end else if (srst_q) begin
         nv_q   <= 1'b0;
      end else begin
         if (start_rd)
            nv_q <= 1'b1;
         else if (eng_done && eng_rd)
            nv_q <= 1'b0;
         if (eng_done && eng_rd)
            stat_q <= eng_rdata;
      end
   end

   always_comb begin
      host_rdata = '0;
      unique case (host_addr)
         RG_CFG: begin
            host_rdata[CFG_SRST]    = srst_q;
            host_rdata[DIV_W-1:0]   = div_q;
         end
         RG_CMD:   host_rdata[0] = cmd_q;
         RG_ADDR: begin
            host_rdata[PHY_LSB +: PHY_W] = phy_q;
            host_rdata[0 +: REG_W]       = reg_q;
         end
         RG_WDATA: host_rdata[DATA_W-1:0] = wdat_q;
         RG_RDATA: host_rdata[DATA_W-1:0] = stat_q;
         RG_IND: begin
            host_rdata[FLAG_BUSY] = eng_busy;
            host_rdata[FLAG_NVAL] = nv_q;
         end
         default: host_rdata = '0;
      endcase
   end

   mdio_mdc_gen #(.DIV_W(DIV_W)) i_mdc_gen (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (eng_busy),
      .div   (div_q),
      .mdc   (mdc),
      .rise  (mdc_rise),
      .fall  (mdc_fall)
   );

   mdio_frame_engine #(
      .PHY_W   (PHY_W),
      .REG_W   (REG_W),
      .DATA_W  (DATA_W),
      .PRE_LEN (PRE_LEN)
   ) i_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .abort    (srst_q),
      .start    (start_wr || start_rd),
      .start_rd (start_rd),
      .phy      (phy_q),
      .regn     (reg_q),
      .wdata    (host_wdata[DATA_W-1:0]),
      .rise     (mdc_rise),
      .fall     (mdc_fall),
      .mdio_i   (mdio_i),
      .busy     (eng_busy),
      .is_rd    (eng_rd),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .done     (eng_done),
      .rdata    (eng_rdata)
   );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic is_rd,
   input logic nv,
   input logic srst,
   input logic mdc,
   input logic mdio_o,
   input logic mdio_oe
);
   // R4: MDC parks low once no frame is running
   a_r4_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !mdc);

   // R3: a write frame drives the line for every bit
   a_r3_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !is_rd) |-> mdio_oe);

   // R3: each frame opens with a driven preamble one
   a_r3_preamble_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (mdio_oe && mdio_o));

   // R8: NOTVALID only while a frame is in flight
   a_r8_nv_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      nv |-> busy);

   // R9: soft reset clears activity on the next cycle
   a_r9_srst_idle: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (!busy && !nv));

   // R7: the enable is never high outside a frame
   a_r7_oe_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> busy);
endmodule

bind mdio_mgmt_master mdio_mgmt_chk i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (eng_busy),
   .is_rd   (eng_rd),
   .nv      (nv_q),
   .srst    (srst_q),
   .mdc     (mdc),
   .mdio_o  (mdio_o),
   .mdio_oe (mdio_oe)
);

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;
   localparam logic [2:0] A_CFG = 3'd0, A_CMD = 3'd1, A_ADDR = 3'd2,
                          A_WD = 3'd3, A_RD = 3'd4, A_IND = 3'd5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [2:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   mdio_mgmt_master i_mdio_mgmt_master (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic host_wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic host_rd(input logic [2:0] a, output logic [31:0] d);
      host_addr = a;
      #1;
      d = host_rdata;
   endtask

   function automatic logic [63:0] wr_frame(input logic [4:0] p, input logic [4:0] r,
                                            input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
   endfunction

   task automatic capture(input logic [15:0] resp, output logic [63:0] bits,
                          output logic [63:0] oes);
      for (int k = 0; k < 64; k++) begin
         mdio_i = (k >= 48) ? resp[63-k] : 1'b1;
         @(posedge mdc);
         #1;
         bits[63-k] = mdio_o;
         oes[63-k]  = mdio_oe;
      end
      mdio_i = 1'b1;
   endtask

   task automatic wait_idle(input string req);
      logic [31:0] v;
      int n = 0;
      do begin
         @(negedge clk);
         host_rd(A_IND, v);
         n++;
      end while (v[0] && n < 20000);
      chk(req, {63'd0, v[0]}, 64'd0);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      host_rd(A_CFG, v);  chk("R1 cfg", 64'(v), 64'h7);
      host_rd(A_CMD, v);  chk("R1 cmd", 64'(v), 64'h0);
      host_rd(A_ADDR, v); chk("R1 addr", 64'(v), 64'h0);
      host_rd(A_RD, v);   chk("R1 rdata", 64'(v), 64'h0);
      host_rd(A_IND, v);  chk("R1 ind", 64'(v), 64'h0);
      chk("R1 pins", {62'd0, mdc, mdio_oe}, 64'd0);
   endtask

   task automatic t_addr;
      logic [31:0] v;
      host_wr(A_ADDR, 32'hFFFF_FFFF);
      host_rd(A_ADDR, v); chk("R2 mask", 64'(v), 64'h1F1F);
      host_wr(A_ADDR, 32'h0000_150A);
      host_rd(A_ADDR, v); chk("R2 fields", 64'(v), 64'h150A);
   endtask

   task automatic t_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
      logic [63:0] bits, oes;
      logic [31:0] v;
      host_wr(A_ADDR, {19'd0, p, 3'd0, r});
      host_wr(A_WD, {16'd0, d});
      host_rd(A_IND, v); chk("R7 busy set", 64'(v), 64'h1);
      capture(16'h0, bits, oes);
      chk("R3 stream", bits, wr_frame(p, r, d));
      chk("R3 enable", oes, 64'hFFFF_FFFF_FFFF_FFFF);
      wait_idle("R7 busy clear");
   endtask

   task automatic t_mdc(input logic [2:0] dv);
      int n = 0;
      host_wr(A_CFG, {29'd0, dv});
      host_wr(A_WD, 32'h0000_5A5A);
      @(posedge mdc);
      do begin
         @(negedge clk);
         if (mdc) n++;
      end while (mdc);
      chk("R4 half period", 64'(n), 64'(1 << (dv + 1)));
      wait_idle("R4 frame end");
      repeat (2) @(negedge clk);
      chk("R4 idle low", {63'd0, mdc}, 64'd0);
   endtask

   task automatic t_read(input logic [4:0] p, input logic [4:0] r, input logic [15:0] resp);
      logic [63:0] bits, oes;
      logic [31:0] v;
      host_wr(A_ADDR, {19'd0, p, 3'd0, r});
      host_wr(A_CMD, 32'h0);
      host_wr(A_CMD, 32'h1);
      host_rd(A_IND, v); chk("R8 nv and busy", 64'(v), 64'h5);
      capture(resp, bits, oes);
      chk("R6 header", 64'(bits[63:18]), 64'({32'hFFFF_FFFF, 2'b01, 2'b10, p, r}));
      chk("R6 release", oes, {{46{1'b1}}, 18'd0});
      wait_idle("R7 read end");
      host_rd(A_RD, v);  chk("R6 data", 64'(v), 64'(resp));
      host_rd(A_IND, v); chk("R8 nv clear", 64'(v), 64'h0);
   endtask

   task automatic t_no_edge;
      logic [31:0] v;
      host_wr(A_CMD, 32'h1);
      repeat (6) @(negedge clk);
      host_rd(A_IND, v); chk("R5 no restart", 64'(v), 64'h0);
      chk("R5 line idle", {63'd0, mdio_oe}, 64'd0);
      t_read(5'h1F, 5'h11, 16'hBEEF);
   endtask

   task automatic t_busy_ignore;
      logic [63:0] bits, oes;
      logic [31:0] v, prev;
      host_rd(A_RD, prev);
      host_wr(A_ADDR, 32'h0000_0904);
      host_wr(A_CMD, 32'h0);
      host_wr(A_WD, 32'h0000_1111);
      fork
         capture(16'h0, bits, oes);
         begin
            repeat (12) @(negedge clk);
            host_wr(A_WD, 32'h0000_2222);
            host_wr(A_CMD, 32'h1);
         end
      join
      chk("R10 frame kept", bits, wr_frame(5'h09, 5'h04, 16'h1111));
      wait_idle("R10 end");
      repeat (8) @(negedge clk);
      host_rd(A_IND, v); chk("R10 nothing queued", 64'(v), 64'h0);
      host_rd(A_RD, v);  chk("R10 rdata kept", 64'(v), 64'(prev));
   endtask

   task automatic t_srst;
      logic [31:0] v;
      host_wr(A_CMD, 32'h0);
      host_wr(A_CMD, 32'h1);
      repeat (20) @(negedge clk);
      host_wr(A_CFG, 32'h8000_0000);
      repeat (2) @(negedge clk);
      host_rd(A_IND, v); chk("R9 flags clear", 64'(v), 64'h0);
      chk("R9 pins idle", {62'd0, mdc, mdio_oe}, 64'd0);
      host_wr(A_WD, 32'h0000_7777);
      repeat (4) @(negedge clk);
      host_rd(A_IND, v); chk("R9 start blocked", 64'(v), 64'h0);
      host_wr(A_CFG, 32'h0);
      t_write(5'h02, 5'h1D, 16'hC001);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_addr();
      host_wr(A_CFG, 32'h0);
      t_write(5'h15, 5'h0A, 16'hA5C3);
      t_write(5'h1F, 5'h00, 16'h0001);
      t_mdc(3'd0);
      t_mdc(3'd1);
      t_mdc(3'd2);
      host_wr(A_CFG, 32'h0);
      t_read(5'h03, 5'h02, 16'h1234);
      t_no_edge();
      t_busy_ignore();
      t_srst();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule